// File: doc/BRIEF.md
# Single-Character Serial Channel Register Core

This block holds the software-visible registers of a simple asynchronous serial channel that buffers one character in each direction. A byte-wide bus reaches six registers: frame mode, channel control, bit rate, outgoing character, incoming character and status. On the line side it presents one character at a time to a transmitter through a valid/accept pair, and it takes one character at a time from a receiver through a valid/ready pair.

The status register keeps its own flag discipline. Software can only clear a flag, and only after it has read that flag as 1. The core also tracks overrun and transmit completion. It decodes the mode register into frame parameters and a scaled divisor for an external bit-rate generator. Serialisation and the baud counter sit outside.

Top module: `serial_regs_core`

## Requirements
- R1: After reset the status register (address 4) reads 0x84, the mode register (address 0) reads 0x00, `txValid` and `rxReady` are 0 and `rateDivisor` is 0.
- R2: A status flag in bits 7..3 (bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun) clears only when a status write carries 0 in that bit and the flag was read as 1 earlier; flags never read stay set.
- R3: A status write never sets a flag in bits 7..3. Every bit written as 0 drops out of the read record, so clearing the same flag again takes a new read.
- R4: Status bit 0 takes the written value directly and reads back; bit 1 always reads 0.
- R5: While the transmit-enable bit (control bit 5) is 0, any status write leaves transmit-empty (bit 7) and transmit-end (bit 2) at 1.
- R6: Clearing transmit-empty through a status write also clears transmit-end, and writing the outgoing character register (address 3) clears transmit-end.
- R7: While transmit-empty is 0, `txValid` is 1 and `txByte` shows the outgoing character register. An accept on `txAccept` sets transmit-empty and transmit-end for the next cycle.
- R8: `rxReady` follows the receive-enable bit (control bit 4). A character offered while `rxReady` is 0 changes nothing.
- R9: An accepted character with receive-full at 0 is stored and sets receive-full. With receive-full at 1 it is dropped and the overrun flag (bit 5) is set.
- R10: A read of the incoming character register (address 5) returns the stored byte and clears receive-full. A character arriving in that same cycle is stored with no overrun, and receive-full stays 1.
- R11: Mode bit 6 gives 7 data bits (else 8). Bit 5 enables parity and bit 4 selects odd parity. Bit 3 gives 2 stop bits (else 1). `frameParity` reads 0 for none, 1 for even and 2 for odd.
- R12: `rateDivisor` equals the bit-rate register (address 2) times 4 to the power of mode bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register select |
| busWrEn | input | 1 | Write strobe, takes priority over a read |
| busRdEn | input | 1 | Read strobe (side effects apply at the clock edge) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the selected register, combinational |
| txValid | output | 1 | An outgoing character is waiting |
| txByte | output | 8 | Outgoing character |
| txAccept | input | 1 | Transmitter takes the character |
| rxValid | input | 1 | Receiver offers a character |
| rxByte | input | 8 | Offered character |
| rxReady | output | 1 | Receiver path enabled |
| frameDataBits | output | 4 | Data bits per frame, 7 or 8 |
| frameParity | output | 2 | 0 none, 1 even, 2 odd |
| frameStopBits | output | 2 | Stop bits, 1 or 2 |
| rateDivisor | output | 14 | Scaled bit-rate divisor |

## Verification
Two collisions matter here. The first is a read of the incoming character register in the same cycle that the receiver offers a new byte. The bench drives both in one cycle. It expects the old byte on the bus, the new byte stored afterwards, receive-full still set and no overrun. The second is a flag-clearing status write when the read record is stale: the bench sets overrun again after an earlier clear and no new read, and it expects the write to leave the flag set.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;
  localparam int CKS_W = 2;
  localparam int DIV_W = REG_W + 2 * ((1 << CKS_W) - 1);

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_RATE = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd5;

  localparam int B_TDRE = 7;
  localparam int B_RDRF = 6;
  localparam int B_ORER = 5;
  localparam int B_TEND = 2;
  localparam int B_MPBT = 0;
  localparam int B_TXEN = 5;
  localparam int B_RXEN = 4;
  localparam int B_SEVEN = 6;
  localparam int B_PAREN = 4 + 1;
  localparam int B_ODD = 4;
  localparam int B_TWOSTOP = 3;

  localparam logic [REG_W-1:0] FLAG_MASK = 8'hF8;
  localparam logic [REG_W-1:0] TX_FORCE = 8'h84;
  localparam logic [REG_W-1:0] STAT_RESET = 8'h84;

  typedef struct packed {
    logic wrMode;
    logic wrCtrl;
    logic wrRate;
    logic wrTx;
    logic loadRx;
  } strobe_t;
endpackage

// File: rtl/serial_regs_ctrl.sv
module serial_regs_ctrl
  import serial_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              txAccept,
  input  logic              rxValid,
  output strobe_t           strobes,
  output logic [REG_W-1:0]  statusVal,
  output logic              txValid
);
  logic [REG_W-1:0] statusQ, statusNext;
  logic [REG_W-1:0] readMaskQ, maskNext;
  logic [REG_W-1:0] effWrite;
  logic statWr, statRd, rxdRd, txHandoff, rxTake;

  assign statWr    = busWrEn && busAddr == A_STAT;
  assign statRd    = busRdEn && !busWrEn && busAddr == A_STAT;
  assign rxdRd     = busRdEn && !busWrEn && busAddr == A_RXD;
  assign txValid   = !statusQ[B_TDRE];
  assign txHandoff = txValid && txAccept;
  assign rxTake    = rxValid && rxEnable;
  assign effWrite  = busWrData | (txEnable ? '0 : TX_FORCE);

  always_comb begin
    statusNext = statusQ;
    maskNext = readMaskQ;
    strobes.wrMode = busWrEn && busAddr == A_MODE;
    strobes.wrCtrl = busWrEn && busAddr == A_CTRL;
    strobes.wrRate = busWrEn && busAddr == A_RATE;
    strobes.wrTx   = busWrEn && busAddr == A_TXD;
    strobes.loadRx = 1'b0;
    if (statWr) begin
      statusNext = statusQ & ~(readMaskQ & ~effWrite & FLAG_MASK);
      statusNext[B_MPBT] = busWrData[B_MPBT];
      if (!txEnable) begin
        statusNext[B_TDRE] = 1'b1;
        statusNext[B_TEND] = 1'b1;
      end
      if (!statusNext[B_TDRE]) statusNext[B_TEND] = 1'b0;
      maskNext = readMaskQ & effWrite;
    end
    if (statRd) maskNext = readMaskQ | (statusQ & FLAG_MASK);
    if (rxdRd) statusNext[B_RDRF] = 1'b0;
    if (txHandoff) begin
      statusNext[B_TDRE] = 1'b1;
      statusNext[B_TEND] = 1'b1;
    end
    if (strobes.wrTx) statusNext[B_TEND] = 1'b0;
    if (rxTake) begin
      if (statusNext[B_RDRF]) begin
        statusNext[B_ORER] = 1'b1;
      end else begin
        strobes.loadRx = 1'b1;
        statusNext[B_RDRF] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= STAT_RESET;
      readMaskQ <= '0;
    end else begin
      statusQ <= statusNext;
      readMaskQ <= maskNext;
    end
  end

  assign statusVal = statusQ;
endmodule

// File: rtl/serial_regs_dp.sv
module serial_regs_dp
  import serial_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [REG_W-1:0]  rxByte,
  input  strobe_t           strobes,
  input  logic [REG_W-1:0]  statusVal,
  output logic [REG_W-1:0]  busRdData,
  output logic [REG_W-1:0]  txByte,
  output logic              txEnable,
  output logic              rxEnable,
  output logic [3:0]        frameDataBits,
  output logic [1:0]        frameParity,
  output logic [1:0]        frameStopBits,
  output logic [DIV_W-1:0]  rateDivisor
);
  logic [REG_W-1:0] modeQ, ctrlQ, rateQ, txdQ, rxdQ;
  logic [CKS_W-1:0] clkSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      ctrlQ <= '0;
      rateQ <= '0;
      txdQ  <= '0;
      rxdQ  <= '0;
    end else begin
      if (strobes.wrMode) modeQ <= busWrData;
      if (strobes.wrCtrl) ctrlQ <= busWrData;
      if (strobes.wrRate) rateQ <= busWrData;
      if (strobes.wrTx)   txdQ  <= busWrData;
      if (strobes.loadRx) rxdQ  <= rxByte;
    end
  end

  always_comb begin
    unique case (busAddr)
      A_MODE:  busRdData = modeQ;
      A_CTRL:  busRdData = ctrlQ;
      A_RATE:  busRdData = rateQ;
      A_TXD:   busRdData = txdQ;
      A_STAT:  busRdData = statusVal;
      A_RXD:   busRdData = rxdQ;
      default: busRdData = '0;
    endcase
  end

  assign clkSel        = modeQ[CKS_W-1:0];
  assign txByte        = txdQ;
  assign txEnable      = ctrlQ[B_TXEN];
  assign rxEnable      = ctrlQ[B_RXEN];
  assign frameDataBits = modeQ[B_SEVEN] ? 4'd7 : 4'd8;
  assign frameParity   = !modeQ[B_PAREN] ? 2'd0 : (modeQ[B_ODD] ? 2'd2 : 2'd1);
  assign frameStopBits = modeQ[B_TWOSTOP] ? 2'd2 : 2'd1;
  assign rateDivisor   = DIV_W'(rateQ) << (2 * clkSel);
endmodule

// File: rtl/serial_regs_core.sv
module serial_regs_core
  import serial_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output logic              txValid,
  output logic [REG_W-1:0]  txByte,
  input  logic              txAccept,
  input  logic              rxValid,
  input  logic [REG_W-1:0]  rxByte,
  output logic              rxReady,
  output logic [3:0]        frameDataBits,
  output logic [1:0]        frameParity,
  output logic [1:0]        frameStopBits,
  output logic [DIV_W-1:0]  rateDivisor
);
  strobe_t          strobes;
  logic [REG_W-1:0] statusVal;
  logic             txEnable, rxEnable;

  serial_regs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .txEnable(txEnable),
    .rxEnable(rxEnable), .txAccept(txAccept), .rxValid(rxValid),
    .strobes(strobes), .statusVal(statusVal), .txValid(txValid)
  );

  serial_regs_dp u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .rxByte(rxByte), .strobes(strobes), .statusVal(statusVal),
    .busRdData(busRdData), .txByte(txByte), .txEnable(txEnable),
    .rxEnable(rxEnable), .frameDataBits(frameDataBits),
    .frameParity(frameParity), .frameStopBits(frameStopBits),
    .rateDivisor(rateDivisor)
  );

  assign rxReady = rxEnable;
endmodule

// File: rtl/serial_regs_checker.sv
module serial_regs_checker
  import serial_regs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic              txValid,
  input logic              txAccept,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txEnable,
  input logic [REG_W-1:0]  statusVal
);
  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxReady && statusVal[B_RDRF] && !busWrEn && !busRdEn
    |=> statusVal[B_ORER]); // R9

  AST_HANDOFF_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txAccept && !(busWrEn && busAddr == A_TXD)
    |=> statusVal[B_TDRE] && statusVal[B_TEND]); // R7

  AST_IGNORED_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady && !busWrEn && !busRdEn
    |=> $stable(statusVal[B_RDRF:B_ORER])); // R8

  AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_STAT && txEnable && !txAccept && !(rxValid && rxReady)
    |=> (statusVal & ~$past(statusVal) & FLAG_MASK) == '0); // R3

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !busWrEn && busAddr == A_RXD && !(rxValid && rxReady)
    |=> !statusVal[B_RDRF]); // R10
endmodule

bind serial_regs_core serial_regs_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .txValid(txValid), .txAccept(txAccept),
  .rxValid(rxValid), .rxReady(rxReady), .txEnable(txEnable),
  .statusVal(statusVal)
);

// File: tb/serial_regs_core_bench.sv
module serial_regs_core_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic txValid, txAccept = 1'b0, rxValid = 1'b0, rxReady;
  logic [7:0] txByte, rxByte = '0;
  logic [3:0] frameDataBits;
  logic [1:0] frameParity, frameStopBits;
  logic [13:0] rateDivisor;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_regs_core u_serial_regs_core (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .txValid(txValid), .txByte(txByte), .txAccept(txAccept),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady),
    .frameDataBits(frameDataBits), .frameParity(frameParity),
    .frameStopBits(frameStopBits), .rateDivisor(rateDivisor)
  );

  // {read?, addr, data or expected, requirement number}
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 3'd4, 8'h84, 4'd1},   // R1 status reset
    {1'b1, 3'd0, 8'h00, 4'd1},   // R1 mode reset
    {1'b0, 3'd1, 8'h20, 4'd5},   // enable transmitter
    {1'b0, 3'd4, 8'h00, 4'd2},   // clear read transmit-empty
    {1'b1, 3'd4, 8'h00, 4'd6},   // R6 transmit-end follows
    {1'b0, 3'd4, 8'h01, 4'd4},
    {1'b1, 3'd4, 8'h01, 4'd4},   // R4 bit 0 direct
    {1'b0, 3'd0, 8'h7A, 4'd11},
    {1'b1, 3'd0, 8'h7A, 4'd11},  // R11 mode readback
    {1'b0, 3'd3, 8'h5A, 4'd7},
    {1'b1, 3'd3, 8'h5A, 4'd7},   // R7 outgoing register
    {1'b0, 3'd4, 8'hFF, 4'd3},
    {1'b1, 3'd4, 8'h01, 4'd3},   // R3 ones set nothing
    {1'b0, 3'd1, 8'h00, 4'd5},
    {1'b0, 3'd4, 8'h00, 4'd5},
    {1'b1, 3'd4, 8'h84, 4'd5},   // R5 forced while disabled
    {1'b0, 3'd1, 8'h20, 4'd5},
    {1'b0, 3'd4, 8'hFF, 4'd4},
    {1'b1, 3'd4, 8'h85, 4'd4},   // R4 bit 0 set
    {1'b0, 3'd4, 8'h7E, 4'd6}    // R6 clear empty, then end
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [7:0] exp, input string req);
    busAddr = a; busRdEn = 1'b1;
    #1 chk(req, busRdData, exp);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic offerRx(input logic [7:0] b);
    rxByte = b; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 txValid", txValid, 0);
    chk("R1 rxReady", rxReady, 0);
    chk("R1 divisor", rateDivisor, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15]) busRead(VEC[i][14:12], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else busWrite(VEC[i][14:12], VEC[i][11:4]);
    end
    busRead(3'd4, 8'h00, "R6 after clear");

    // R7 handoff
    #1 chk("R7 txValid", txValid, 1);
    chk("R7 txByte", txByte, 8'h5A);
    txAccept = 1'b1;
    @(negedge clk);
    txAccept = 1'b0;
    #1 chk("R7 txValid after accept", txValid, 0);
    @(negedge clk);
    busRead(3'd4, 8'h84, "R7 status after accept");

    // R11 R12 decode
    #1 chk("R11 data bits", frameDataBits, 7);
    chk("R11 odd parity", frameParity, 2);
    chk("R11 two stops", frameStopBits, 2);
    @(negedge clk);
    busWrite(3'd2, 8'h05);
    #1 chk("R12 divisor x16", rateDivisor, 80);
    @(negedge clk);
    busWrite(3'd0, 8'h23);
    #1 chk("R12 divisor x64", rateDivisor, 320);
    chk("R11 even parity", frameParity, 1);
    chk("R11 eight bits", frameDataBits, 8);
    chk("R11 one stop", frameStopBits, 1);
    @(negedge clk);

    // R8 ignored while receiver disabled
    offerRx(8'h11);
    busRead(3'd4, 8'h84, "R8 ignored offer");
    busWrite(3'd1, 8'h30);
    #1 chk("R8 rxReady", rxReady, 1);
    @(negedge clk);

    // R9 store and overrun
    offerRx(8'h22);
    offerRx(8'h33);
    busRead(3'd4, 8'hE4, "R9 overrun flag");
    busRead(3'd5, 8'h22, "R9 first byte kept");
    busRead(3'd4, 8'hA4, "R10 read clears full");

    // R2 R3 clear rules
    busWrite(3'd4, 8'hDE);
    busRead(3'd4, 8'h84, "R2 overrun cleared");
    offerRx(8'h44);
    offerRx(8'h55);
    busWrite(3'd4, 8'hDE);
    busRead(3'd4, 8'hE4, "R3 stale record keeps flag");
    busRead(3'd5, 8'h44, "R9 byte after overrun");
    busWrite(3'd4, 8'hDE);
    busRead(3'd4, 8'h84, "R2 cleared after fresh read");

    // R10 read and arrival in one cycle
    offerRx(8'h66);
    busAddr = 3'd5; busRdEn = 1'b1; rxByte = 8'h77; rxValid = 1'b1;
    #1 chk("R10 same-cycle read data", busRdData, 8'h66);
    @(negedge clk);
    busRdEn = 1'b0; rxValid = 1'b0;
    busRead(3'd4, 8'hC4, "R10 full kept, no overrun");
    busRead(3'd5, 8'h77, "R10 new byte stored");

    // R6 outgoing write clears transmit-end
    busWrite(3'd3, 8'h99);
    busRead(3'd4, 8'h80, "R6 data write clears end");
    #1 chk("R7 no handoff while empty set", txValid, 0);
    finish();
  end
endmodule